// File: doc/BRIEF.md
# Switchable Accelerator Frame Interconnect

This block is a small one-way streaming fabric between a local input memory bank, a set of pluggable accelerator frames and a separate local output memory bank. For each block of work, software first writes a routing word. That word states which source feeds each frame and which source feeds the output bank, so the frames can be chained in any order or skipped. Software then writes the start register. An internal sequencer reads the 64 sixteen-bit elements of the block from the input bank and sends them down the chosen chain.

Every frame port carries data, an element address, a valid strobe forward and a stall signal backward. Each frame passes the element address along with its result. The output bank stores each result at the address that arrives with it, so results land in row-major element order. Once the 64th result is stored, a done bit flips. Polling software can see completion by comparing the bit with its previous reading.

Top module: `accel_route_fabric`

## Requirements
- R1: After reset, busy is 0, done_tgl is 0 and every frame-facing valid (fx_valid) is 0.
- R2: reg_sel 0 writes the routing word and reg_sel 1 is the start command. The routing word has one 2-bit source field per frame: frame k uses bits [2k+1:2k]. The output-bank source field is bits [5:4]. Source codes are 0 = nothing, 1 = input bank, 2 = frame 0, 3 = frame 1.
- R3: With the output-bank source set to the input bank, the output bank receives an exact copy of the 64 input elements.
- R4: With one frame, or with both frames chained in either order, each output element equals the frame functions applied to its input element in chain order.
- R5: An element moves across a link only in a cycle where valid is high and stall is low. A frame that stalls at varying times causes no lost, repeated or reordered results.
- R6: The output bank writes each result at the element address that arrives with it, not at the order of arrival.
- R7: A frame whose source field is 0 sees fx_valid held low for the whole block, and no frame sees valid while the fabric is idle.
- R8: done_tgl inverts exactly once per block, in the same cycle that busy falls. This happens only after all 64 results are stored.
- R9: A routing-word write while busy is dropped. The next block still uses the earlier routing word.
- R10: A start while busy is ignored: the block in flight is not restarted and produces one done toggle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = routing word, 1 = start command |
| reg_wdata | input | 6 | Routing word value |
| in_wr | input | 1 | Input bank write strobe |
| in_addr | input | 6 | Input bank write address |
| in_wdata | input | 16 | Input bank write data |
| out_addr | input | 6 | Output bank read address |
| out_rdata | output | 16 | Output bank read data (combinational) |
| busy | output | 1 | Block in flight |
| done_tgl | output | 1 | Completion bit, inverts per finished block |
| fx_valid | output | 2 | Per-frame valid into the frame |
| fx_data | output | 32 | Per-frame element data into the frame, 16 bits each |
| fx_addr | output | 12 | Per-frame element address into the frame, 6 bits each |
| fx_stall | input | 2 | Per-frame stall raised by the frame on its input side |
| fr_valid | input | 2 | Per-frame result valid |
| fr_data | input | 32 | Per-frame result data |
| fr_addr | input | 12 | Per-frame result element address |
| fr_stall | output | 2 | Per-frame stall raised by the fabric on the frame's result |

## Verification
The read pointer and the write count are the internal state that can go wrong. A read pointer that advances while stalled shows at the ports as a skipped input, so a wrong value appears in the output bank after the next done toggle. A wrong write count moves the done toggle early or late, or makes it never arrive. The bench waits a bounded time for the toggle. A routing word that changes mid-block shows as a whole block of wrong results. A wrongly steered valid shows in the same cycle on an unused frame's fx_valid.

// File: rtl/accel_route_fabric.sv
module accel_route_fabric #(
  parameter int DW = 16,
  parameter int NELEM = 64,
  parameter int NF = 2,
  localparam int AW = $clog2(NELEM),
  localparam int SW = $clog2(NF + 2),
  localparam int CFGW = (NF + 1) * SW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [CFGW-1:0] reg_wdata,
  input  logic            in_wr,
  input  logic [AW-1:0]   in_addr,
  input  logic [DW-1:0]   in_wdata,
  input  logic [AW-1:0]   out_addr,
  output logic [DW-1:0]   out_rdata,
  output logic            busy,
  output logic            done_tgl,
  output logic [NF-1:0]   fx_valid,
  output logic [NF*DW-1:0] fx_data,
  output logic [NF*AW-1:0] fx_addr,
  input  logic [NF-1:0]   fx_stall,
  input  logic [NF-1:0]   fr_valid,
  input  logic [NF*DW-1:0] fr_data,
  input  logic [NF*AW-1:0] fr_addr,
  output logic [NF-1:0]   fr_stall
);
  localparam logic [AW:0] NCNT = (AW + 1)'(NELEM);

  logic [DW-1:0]   ibuf [NELEM];
  logic [DW-1:0]   obuf [NELEM];
  logic [CFGW-1:0] cfg_q;
  logic [AW:0]     rd_ptr, wr_cnt;
  logic            busy_q, done_q;

  logic            pv [NF+1];
  logic [DW-1:0]   pd [NF+1];
  logic [AW-1:0]   pa [NF+1];
  logic [NF:0]     ps;

  logic            sink_v;
  logic [DW-1:0]   sink_d;
  logic [AW-1:0]   sink_a;
  logic            sink_fire;

  assign busy      = busy_q;
  assign done_tgl  = done_q;
  assign out_rdata = obuf[out_addr];

  assign pv[0] = busy_q && (rd_ptr < NCNT);
  assign pd[0] = ibuf[rd_ptr[AW-1:0]];
  assign pa[0] = rd_ptr[AW-1:0];

  for (genvar k = 0; k < NF; k++) begin : g_prod
    assign pv[k+1]     = fr_valid[k];
    assign pd[k+1]     = fr_data[k*DW +: DW];
    assign pa[k+1]     = fr_addr[k*AW +: AW];
    assign fr_stall[k] = ps[k+1];
  end

  always_comb begin
    int idx;
    ps       = '0;
    fx_valid = '0;
    fx_data  = '0;
    fx_addr  = '0;
    sink_v   = 1'b0;
    sink_d   = '0;
    sink_a   = '0;
    for (int k = 0; k < NF; k++) begin
      idx = int'(cfg_q[k*SW +: SW]) - 1;
      if (idx >= 0 && idx <= NF) begin
        fx_valid[k]          = busy_q && pv[idx];
        fx_data[k*DW +: DW]  = pd[idx];
        fx_addr[k*AW +: AW]  = pa[idx];
        ps[idx]              = ps[idx] | fx_stall[k];
      end
    end
    idx = int'(cfg_q[NF*SW +: SW]) - 1;
    if (idx >= 0 && idx <= NF) begin
      sink_v = pv[idx];
      sink_d = pd[idx];
      sink_a = pa[idx];
    end
  end

  assign sink_fire = busy_q && sink_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_ptr <= '0;
      wr_cnt <= '0;
      cfg_q  <= '0;
    end else begin
      if (reg_wr && !busy_q) begin
        if (reg_sel) begin
          busy_q <= 1'b1;
          rd_ptr <= '0;
          wr_cnt <= '0;
        end else begin
          cfg_q <= reg_wdata;
        end
      end
      if (pv[0] && !ps[0]) rd_ptr <= rd_ptr + 1'b1;
      if (sink_fire) begin
        wr_cnt <= wr_cnt + 1'b1;
        if (wr_cnt == NCNT - 1'b1) begin
          busy_q <= 1'b0;
          done_q <= ~done_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_wr) ibuf[in_addr] <= in_wdata;
    if (sink_fire) obuf[sink_a] <= sink_d;
  end

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (fx_valid == '0));

  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != $past(done_q)) |-> ($past(busy_q) && !busy_q && $past(wr_cnt) == NCNT - 1'b1));

  // R8
  wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt <= NCNT) && (rd_ptr <= NCNT));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(cfg_q));

  // R10
  no_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (rd_ptr >= $past(rd_ptr) && wr_cnt >= $past(wr_cnt)));
endmodule

// File: tb/accel_route_fabric_tb_top.sv
module accel_route_fabric_tb_top;
  localparam int DW = 16, AW = 6, NE = 64, NF = 2;
  localparam logic [DW-1:0] KADD = 16'h0105;
  localparam logic [5:0] C_BYP = 6'h10, C_A = 6'h21, C_B = 6'h34, C_AB = 6'h39, C_BA = 6'h27;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0, in_wr = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [AW-1:0] in_addr = '0, out_addr = '0;
  logic [DW-1:0] in_wdata = '0, out_rdata;
  logic busy, done_tgl;
  logic [NF-1:0] fx_valid, fx_stall, fr_valid, fr_stall;
  logic [NF*DW-1:0] fx_data, fr_data;
  logic [NF*AW-1:0] fx_addr, fr_addr;

  int errors = 0, checks = 0;
  int done_cnt = 0, unused_hits = 0;
  logic [NF-1:0] unused_mask = '0;
  logic flip = 1'b0;
  logic [DW-1:0] src [NE];
  logic prev_done = 1'b0;

  always #4 clk = ~clk;

  accel_route_fabric dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .in_wr(in_wr), .in_addr(in_addr), .in_wdata(in_wdata), .out_addr(out_addr),
    .out_rdata(out_rdata), .busy(busy), .done_tgl(done_tgl),
    .fx_valid(fx_valid), .fx_data(fx_data), .fx_addr(fx_addr), .fx_stall(fx_stall),
    .fr_valid(fr_valid), .fr_data(fr_data), .fr_addr(fr_addr), .fr_stall(fr_stall));

  // stand-in frame 0: adds a constant, optional address mirror
  assign fr_valid[0]    = fx_valid[0];
  assign fr_data[15:0]  = fx_data[15:0] + KADD;
  assign fr_addr[5:0]   = flip ? ~fx_addr[5:0] : fx_addr[5:0];
  assign fx_stall[0]    = fr_stall[0];

  // stand-in frame 1: one-slot shifter with pseudo-random output gaps
  logic bv; logic [DW-1:0] bd; logic [AW-1:0] ba; logic [7:0] lfsr;
  logic gate, b_fire, b_acc;
  assign gate          = lfsr[0] & lfsr[3];
  assign b_fire        = bv && !gate && !fr_stall[1];
  assign fr_valid[1]   = bv && !gate;
  assign fr_data[31:16] = bd;
  assign fr_addr[11:6] = ba;
  assign fx_stall[1]   = bv && !b_fire;
  assign b_acc         = fx_valid[1] && !fx_stall[1];

  always @(posedge clk) begin
    if (!rst_n) begin
      bv <= 1'b0; bd <= '0; ba <= '0; lfsr <= 8'h5B;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (b_acc) begin
        bv <= 1'b1; bd <= fx_data[31:16] >> 1; ba <= fx_addr[11:6];
      end else if (b_fire) bv <= 1'b0;
    end
    if ((fx_valid & unused_mask) != '0) unused_hits <= unused_hits + 1;
    prev_done <= done_tgl;
    if (rst_n && done_tgl != prev_done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [5:0] c, input logic [DW-1:0] x);
    case (c)
      C_A:     return x + KADD;
      C_B:     return x >> 1;
      C_AB:    return (x + KADD) >> 1;
      C_BA:    return (x >> 1) + KADD;
      default: return x;
    endcase
  endfunction

  task automatic load(input int seed);
    for (int i = 0; i < NE; i++) begin
      @(negedge clk);
      src[i] = 16'(i * 16'h1357 + seed * 16'h0F1) ^ 16'hA5C3;
      in_wr = 1'b1; in_addr = AW'(i); in_wdata = src[i];
    end
    @(negedge clk); in_wr = 1'b0;
  endtask

  task automatic regw(input logic sel, input logic [5:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic old = done_tgl;
    int n = 0;
    while (done_tgl == old && n < 3000) begin @(negedge clk); n++; end
    check(req, done_tgl != old, n, 0);
  endtask

  task automatic cmp_out(input string req, input logic [5:0] c, input logic mirror);
    int bad = 0, fa = 0, fe = 0;
    for (int i = 0; i < NE; i++) begin
      logic [DW-1:0] e = model(c, src[i]);
      @(negedge clk); out_addr = mirror ? AW'(63 - i) : AW'(i);
      #1;
      if (out_rdata !== e) begin
        if (bad == 0) begin fa = int'(out_rdata); fe = int'(e); end
        bad++;
      end
    end
    check(req, bad == 0, fa, fe);
  endtask

  task automatic run_route(input string req, input logic [5:0] c, input logic [NF-1:0] um, input int seed);
    int d0;
    load(seed);
    regw(1'b0, c);
    unused_mask = um; unused_hits = 0; d0 = done_cnt;
    regw(1'b1, '0);
    wait_done(req);
    @(negedge clk);
    check({req, " busy low"}, busy == 1'b0, busy, 0);
    check("R8 one toggle", done_cnt - d0 == 1, done_cnt - d0, 1);
    check("R7 unused frame quiet", unused_hits == 0, unused_hits, 0);
    cmp_out(req, c, 1'b0);
    unused_mask = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy", busy == 1'b0, busy, 0);
    check("R1 done_tgl", done_tgl == 1'b0, done_tgl, 0);
    check("R1 fx_valid", fx_valid == '0, fx_valid, 0);
  endtask

  task automatic t_addr_carry();
    load(7);
    regw(1'b0, C_A);
    flip = 1'b1;
    regw(1'b1, '0);
    wait_done("R6 mirror");
    flip = 1'b0;
    cmp_out("R6 address placement", C_A, 1'b1);
  endtask

  task automatic t_cfg_busy();
    load(9);
    regw(1'b0, C_A);
    regw(1'b1, '0);
    regw(1'b0, C_BYP);
    check("R9 busy at write", busy == 1'b1, busy, 1);
    wait_done("R9 block");
    cmp_out("R9 cfg ignored block1", C_A, 1'b0);
    load(10);
    regw(1'b1, '0);
    wait_done("R9 block2");
    cmp_out("R9 cfg ignored block2", C_A, 1'b0);
  endtask

  task automatic t_start_busy();
    int d0;
    load(11);
    regw(1'b0, C_AB);
    d0 = done_cnt;
    regw(1'b1, '0);
    repeat (20) @(negedge clk);
    regw(1'b1, '0);
    wait_done("R10 block");
    repeat (300) @(negedge clk);
    check("R10 single toggle", done_cnt - d0 == 1, done_cnt - d0, 1);
    check("R10 idle", busy == 1'b0, busy, 0);
    cmp_out("R10 results", C_AB, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run_route("R3 bypass", C_BYP, 2'b11, 1);
    run_route("R4 frame0 only", C_A, 2'b10, 2);
    run_route("R5 R4 frame1 only stalls", C_B, 2'b01, 3);
    run_route("R5 R4 chain 0 then 1", C_AB, 2'b00, 4);
    run_route("R4 R2 chain 1 then 0", C_BA, 2'b00, 5);
    t_addr_carry();
    t_cfg_busy();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule